// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 4 Kbit serial EEPROM. It is driven by a three-wire serial host through a chip-select, a serial clock and a serial data input, and it answers on one serial data output. The storage is a register array inside the block. A single parameter arranges it as 512 bytes or as 256 sixteen-bit words. The block samples every serial input on the system clock, finds rising edges of the serial clock and decodes each instruction as it arrives: a start bit, a two-bit op-code and an address field. It then reads, writes, erases one location, erases all locations or writes all locations. Software can enable or disable programming.

Each programming instruction is armed only when its last bit has been shifted in. It starts only if chip select drops before the next serial clock rising edge. It then runs a self-timed cycle whose length is set in system clock cycles. During that cycle the data output reports busy whenever chip select is high, and it reports ready once the cycle has ended. The output is high-impedance while chip select is low, which the model shows with an explicit output-enable pin.

Top module: `mwEeprom`

## Requirements
- R1: After reset the output enable is low, programming is disabled, and every storage bit reads as 1.
- R2: An instruction is a start bit 1, then op-code bits (READ = 10), then the address MSB-first. The address has 9 bits for bytes and 8 bits for words. After the last address bit the output drives a dummy 0. After each following serial clock rising edge it drives the next data bit, MSB first.
- R3: The output enable is low while chip select is low, and low in idle states.
- R4: WRITE (op-code 01) takes the address and then as many data bits as the word width, all sampled on serial clock rising edges. When chip select falls in the allowed window, the location holds exactly that data once the cycle ends.
- R5: If chip select falls before the last data bit, or falls only after one more serial clock rising edge, no cycle starts and the storage is unchanged.
- R6: ERASE (op-code 11) sets every bit of the addressed location to 1 once its cycle ends.
- R7: WRITE first erases the target location, so new data fully replaces old data; the result is not the AND of the two.
- R8: Op-code 00 with top address bits 11 sets the enable latch, and with 00 clears it. While the latch is clear, WRITE, ERASE, write-all and erase-all start no cycle and leave the storage unchanged.
- R9: Op-code 00 with top address bits 01 (write-all, followed by data) writes the data to every location. With top address bits 10 (erase-all) it sets every location to all ones.
- R10: The self-timed cycle lasts PROG_CYCLES system clocks. While chip select is high during the cycle the output drives 0, and it drives 1 after the cycle ends until chip select falls.
- R11: Instructions sent while a cycle is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, active high |
| sckIn | input | 1 | Serial clock from the host |
| sdiIn | input | 1 | Serial data from the host |
| sdoOut | output | 1 | Serial data / ready-busy status to the host |
| sdoOe | output | 1 | Output enable; low stands for high-impedance |

## Verification
The bench builds the byte arrangement (WIDE16 = 0) with a 300-cycle programming time. That cycle is longer than one whole serial instruction, so the bench can send a complete instruction inside a running cycle and show that it is ignored. Byte mode uses the longer 9-bit address, so the extended op-code decode is checked on the widest address field. The top address 511 is also reached. The bench is parameterized by word width, so the same tasks can be run with WIDE16 = 1.

// File: rtl/mwPkg.sv
package mwPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_ARM, ST_WAIT, ST_BUSY, ST_RDY
  } mwState_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK = 2'b00;
  localparam logic [1:0] EXT_WRAL = 2'b01;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_OPEN = 2'b11;

  localparam logic [1:0] OUT_READ = 2'b00;
  localparam logic [1:0] OUT_BUSY = 2'b01;
  localparam logic [1:0] OUT_RDY  = 2'b10;

  typedef struct packed {
    logic       shiftCmd;
    logic       shiftDat;
    logic       loadRead;
    logic       shiftRead;
    logic       eraseOne;
    logic       eraseAll;
    logic       progOne;
    logic       progAll;
    logic       outEn;
    logic [1:0] outSel;
  } mwStrobe_t;
endpackage

// File: rtl/mwCtrl.sv
module mwCtrl
  import mwPkg::*;
#(
  parameter int WIDE16      = 0,
  parameter int PROG_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csQ,
  input  logic       sckRise,
  input  logic       sdiQ,
  input  logic [1:0] opCode,
  input  logic [1:0] addrTop,
  output mwStrobe_t  stb,
  output logic       busy,
  output logic       wen
);
  localparam int W      = (WIDE16 != 0) ? 16 : 8;
  localparam int AW     = (WIDE16 != 0) ? 8 : 9;
  localparam int CMDLEN = AW + 2;
  localparam int CNT_W  = 5;
  localparam int CYC_W  = $clog2(PROG_CYCLES + 1);

  mwState_t state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [CYC_W-1:0] cyc, cycNext;
  logic wenNext;

  always_comb begin
    stNext  = state;
    cntNext = bitCnt;
    cycNext = cyc;
    wenNext = wen;
    stb     = '0;
    if (state == ST_BUSY) begin
      cycNext = cyc + 1'b1;
      if (cyc == CYC_W'(PROG_CYCLES - 1)) begin
        stb.progOne = (opCode == OP_WRITE);
        stb.progAll = (opCode == OP_EXT) && (addrTop == EXT_WRAL);
        stNext      = csQ ? ST_RDY : ST_IDLE;
      end
    end else if (!csQ) begin
      if (state == ST_ARM) begin
        stNext       = ST_BUSY;
        cycNext      = '0;
        stb.eraseOne = (opCode != OP_EXT);
        stb.eraseAll = (opCode == OP_EXT);
      end else begin
        stNext = ST_IDLE;
      end
    end else begin
      case (state)
        ST_IDLE: if (sckRise && sdiQ) begin
          stNext  = ST_CMD;
          cntNext = '0;
        end
        ST_CMD: begin
          if (bitCnt == CNT_W'(CMDLEN)) begin
            cntNext = '0;
            case (opCode)
              OP_READ: begin
                stb.loadRead = 1'b1;
                stNext       = ST_READ;
              end
              OP_WRITE: stNext = wen ? ST_DATA : ST_WAIT;
              OP_ERASE: stNext = wen ? ST_ARM : ST_WAIT;
              default: begin
                case (addrTop)
                  EXT_LOCK: begin wenNext = 1'b0; stNext = ST_WAIT; end
                  EXT_OPEN: begin wenNext = 1'b1; stNext = ST_WAIT; end
                  EXT_WRAL: stNext = wen ? ST_DATA : ST_WAIT;
                  default:  stNext = wen ? ST_ARM : ST_WAIT;
                endcase
              end
            endcase
          end else if (sckRise) begin
            stb.shiftCmd = 1'b1;
            cntNext      = bitCnt + 1'b1;
          end
        end
        ST_DATA: if (sckRise) begin
          stb.shiftDat = 1'b1;
          if (bitCnt == CNT_W'(W - 1)) stNext = ST_ARM;
          else cntNext = bitCnt + 1'b1;
        end
        ST_ARM:  if (sckRise) stNext = ST_WAIT;
        ST_READ: if (sckRise) stb.shiftRead = 1'b1;
        default: ;
      endcase
    end
    stb.outEn  = csQ && (state == ST_READ || state == ST_BUSY || state == ST_RDY);
    stb.outSel = (state == ST_BUSY) ? OUT_BUSY : (state == ST_RDY) ? OUT_RDY : OUT_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      cyc    <= '0;
      wen    <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      cyc    <= cycNext;
      wen    <= wenNext;
    end
  end

  assign busy = (state == ST_BUSY);
endmodule

// File: rtl/mwData.sv
module mwData
  import mwPkg::*;
#(
  parameter int WIDE16 = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csIn,
  input  logic       sckIn,
  input  logic       sdiIn,
  input  mwStrobe_t  stb,
  output logic       csQ,
  output logic       sckRise,
  output logic       sdiQ,
  output logic [1:0] opCode,
  output logic [1:0] addrTop,
  output logic       sdoOut,
  output logic       sdoOe
);
  localparam int W      = (WIDE16 != 0) ? 16 : 8;
  localparam int AW     = (WIDE16 != 0) ? 8 : 9;
  localparam int DEPTH  = 1 << AW;
  localparam int CMDLEN = AW + 2;

  logic sckQ, sckPrev;
  logic [CMDLEN-1:0] cmdReg;
  logic [W-1:0] datReg;
  logic [W:0] rdShift;
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] addr;

  assign addr    = cmdReg[AW-1:0];
  assign opCode  = cmdReg[CMDLEN-1:CMDLEN-2];
  assign addrTop = cmdReg[AW-1:AW-2];
  assign sckRise = sckQ && !sckPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csQ     <= 1'b0;
      sckQ    <= 1'b0;
      sckPrev <= 1'b0;
      sdiQ    <= 1'b0;
      cmdReg  <= '0;
      datReg  <= '0;
      rdShift <= '0;
    end else begin
      csQ     <= csIn;
      sckQ    <= sckIn;
      sckPrev <= sckQ;
      sdiQ    <= sdiIn;
      if (stb.shiftCmd) cmdReg <= {cmdReg[CMDLEN-2:0], sdiQ};
      if (stb.shiftDat) datReg <= {datReg[W-2:0], sdiQ};
      if (stb.loadRead) rdShift <= {1'b0, mem[addr]};
      else if (stb.shiftRead) rdShift <= {rdShift[W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (stb.eraseAll) for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      if (stb.progAll)  for (int i = 0; i < DEPTH; i++) mem[i] <= datReg;
      if (stb.eraseOne) mem[addr] <= '1;
      if (stb.progOne)  mem[addr] <= datReg;
    end
  end

  assign sdoOe  = stb.outEn;
  assign sdoOut = (stb.outSel == OUT_READ) ? rdShift[W] : (stb.outSel == OUT_RDY);
endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwPkg::*;
#(
  parameter int WIDE16      = 0,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csIn,
  input  logic sckIn,
  input  logic sdiIn,
  output logic sdoOut,
  output logic sdoOe
);
  mwStrobe_t  stb;
  logic       csQ, sckRise, sdiQ, busy, wen;
  logic [1:0] opCode, addrTop;

  mwCtrl #(.WIDE16(WIDE16), .PROG_CYCLES(PROG_CYCLES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .csQ(csQ), .sckRise(sckRise), .sdiQ(sdiQ),
    .opCode(opCode), .addrTop(addrTop), .stb(stb), .busy(busy), .wen(wen)
  );

  mwData #(.WIDE16(WIDE16)) uData (
    .clk(clk), .rst_n(rst_n), .csIn(csIn), .sckIn(sckIn), .sdiIn(sdiIn),
    .stb(stb), .csQ(csQ), .sckRise(sckRise), .sdiQ(sdiQ),
    .opCode(opCode), .addrTop(addrTop), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );
endmodule

// File: rtl/mwEepromChk.sv
module mwEepromChk
  import mwPkg::*;
#(
  parameter int PROG_CYCLES = 2000
) (
  input logic      clk,
  input logic      rst_n,
  input logic      csIn,
  input logic      sdoOe,
  input logic      sdoOut,
  input logic      busy,
  input logic      wen,
  input mwStrobe_t stb
);
  localparam int CYC_W = $clog2(PROG_CYCLES + 2);
  logic [CYC_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  assert_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sdoOe |-> $past(csIn));
  assert_busyLow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdoOe) |-> !sdoOut);
  assert_busyLen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= CYC_W'(PROG_CYCLES));
  assert_noProgOff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);
  assert_oneStrobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.eraseOne, stb.eraseAll, stb.progOne, stb.progAll}));
  assert_progInCycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.progOne || stb.progAll) |-> busy);
endmodule

bind mwEeprom mwEepromChk #(.PROG_CYCLES(PROG_CYCLES)) uChk (.*);

// File: tb/mwEeprom_bench.sv
module mwEeprom_bench;
  localparam int WIDE16 = 0;
  localparam int PROG   = 300;
  localparam int W      = (WIDE16 != 0) ? 16 : 8;
  localparam int AW     = (WIDE16 != 0) ? 8 : 9;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csIn = 1'b0, sckIn = 1'b0, sdiIn = 1'b0;
  logic sdoOut, sdoOe;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] refMem [DEPTH];

  always #4 clk = ~clk;

  mwEeprom #(.WIDE16(WIDE16), .PROG_CYCLES(PROG)) u_mwEeprom (
    .clk(clk), .rst_n(rst_n), .csIn(csIn), .sckIn(sckIn), .sdiIn(sdiIn),
    .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdiIn = b; waitNeg(2);
    sckIn = 1'b1; waitNeg(4);
    sckIn = 1'b0; waitNeg(2);
  endtask

  task automatic sendHead(input logic [1:0] op, input logic [AW-1:0] a);
    csIn = 1'b1; waitNeg(2);
    pulse(1'b1); pulse(op[1]); pulse(op[0]);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic sendData(input logic [W-1:0] d, input int nBits);
    for (int i = 0; i < nBits; i++) pulse(d[W-1-i]);
  endtask

  task automatic csLow();
    waitNeg(2); csIn = 1'b0; waitNeg(4);
  endtask

  task automatic waitReady(input string req);
    int n = 0;
    csIn = 1'b1; waitNeg(3);
    while (!(sdoOe && sdoOut) && n < 3 * PROG) begin waitNeg(1); n++; end
    check(sdoOe && sdoOut, req, {30'd0, sdoOe, sdoOut}, 32'h3);
    csIn = 1'b0; waitNeg(4);
  endtask

  task automatic checkIdle(input string req);
    csIn = 1'b1; waitNeg(4);
    check(!sdoOe, req, {31'd0, sdoOe}, 32'h0);
    csIn = 1'b0; waitNeg(4);
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input string req);
    logic [W-1:0] got;
    sendHead(2'b10, a); waitNeg(2);
    check(sdoOe && !sdoOut, "R2 dummy zero", {30'd0, sdoOe, sdoOut}, 32'h2);
    for (int i = W - 1; i >= 0; i--) begin pulse(1'b0); got[i] = sdoOut; end
    check(got == refMem[a], req, 32'(got), 32'(refMem[a]));
    csLow();
    check(!sdoOe, "R3 hiz after cs low", {31'd0, sdoOe}, 32'h0);
  endtask

  task automatic extCmd(input logic [1:0] sel);
    sendHead(2'b00, {sel, {(AW-2){1'b0}}}); csLow();
  endtask

  task automatic testReset();
    check(!sdoOe, "R1 oe low at reset", {31'd0, sdoOe}, 32'h0);
    readCheck('0, "R1 erased at reset");
    readCheck(AW'(DEPTH - 1), "R1 erased top");
  endtask

  task automatic testLocked();
    sendHead(2'b01, AW'(5)); sendData(W'(16'h5A3C), W); csLow();
    checkIdle("R8 no cycle when locked");
    readCheck(AW'(5), "R8 locked write ignored");
  endtask

  task automatic testWriteTiming();
    int n;
    extCmd(2'b11);
    sendHead(2'b01, AW'(5)); sendData(W'(16'h0F0F), W);
    waitNeg(2); csIn = 1'b0; n = 0;
    waitNeg(3); n += 3; csIn = 1'b1; waitNeg(1); n++;
    check(sdoOe && !sdoOut, "R10 busy shown", {30'd0, sdoOe, sdoOut}, 32'h2);
    while (!(sdoOe && sdoOut) && n < 3 * PROG) begin waitNeg(1); n++; end
    check(n >= PROG && n <= PROG + 4, "R10 cycle length", 32'(n), 32'(PROG + 2));
    csIn = 1'b0; waitNeg(4);
    refMem[5] = W'(16'h0F0F);
    readCheck(AW'(5), "R4 write data");
    sendHead(2'b01, AW'(5)); sendData(W'(16'hF0F0), W); csLow();
    waitReady("R7 ready");
    refMem[5] = W'(16'hF0F0);
    readCheck(AW'(5), "R7 auto erase replaces data");
    sendHead(2'b01, AW'(DEPTH - 1)); sendData(W'(16'h1234), W); csLow();
    waitReady("R4 ready top");
    refMem[DEPTH-1] = W'(16'h1234);
    readCheck(AW'(DEPTH - 1), "R4 top address");
  endtask

  task automatic testWindow();
    sendHead(2'b01, AW'(6)); sendData(W'(16'h0000), W - 1); csLow();
    checkIdle("R5 early no cycle");
    readCheck(AW'(6), "R5 early unchanged");
    sendHead(2'b01, AW'(6)); sendData(W'(16'h0000), W); pulse(1'b0); csLow();
    checkIdle("R5 late no cycle");
    readCheck(AW'(6), "R5 late unchanged");
  endtask

  task automatic testErase();
    sendHead(2'b11, AW'(5)); csLow();
    waitReady("R6 ready");
    refMem[5] = '1;
    readCheck(AW'(5), "R6 erase ones");
  endtask

  task automatic testAll();
    sendHead(2'b00, {2'b01, {(AW-2){1'b0}}}); sendData(W'(16'hA5C3), W); csLow();
    waitReady("R9 wral ready");
    for (int i = 0; i < DEPTH; i++) refMem[i] = W'(16'hA5C3);
    readCheck(AW'(0), "R9 wral low");
    readCheck(AW'(DEPTH - 1), "R9 wral high");
    extCmd(2'b10);
    waitReady("R9 eral ready");
    for (int i = 0; i < DEPTH; i++) refMem[i] = '1;
    readCheck(AW'(77), "R9 eral");
  endtask

  task automatic testBusyIgnore();
    sendHead(2'b01, AW'(7)); sendData(W'(16'h1111), W); csLow();
    sendHead(2'b01, AW'(8));
    check(sdoOe && !sdoOut, "R11 busy during instr", {30'd0, sdoOe, sdoOut}, 32'h2);
    sendData(W'(16'h2222), W); csLow();
    waitReady("R11 ready");
    refMem[7] = W'(16'h1111);
    readCheck(AW'(7), "R11 first write");
    readCheck(AW'(8), "R11 ignored write");
  endtask

  task automatic testLockAgain();
    extCmd(2'b00);
    sendHead(2'b11, AW'(7)); csLow();
    checkIdle("R8 locked erase no cycle");
    readCheck(AW'(7), "R8 locked erase ignored");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '1;
    waitNeg(5); rst_n = 1'b1; waitNeg(3);
    testReset();
    testLocked();
    testWriteTiming();
    testWindow();
    testErase();
    testAll();
    testBusyIgnore();
    testLockAgain();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule